// File: doc/BRIEF.md
# Companion Control Register and GPIO Block

This block is a small memory-mapped peripheral. It sits on a simple synchronous register bus and holds a bank of 16-bit control registers and 16 general-purpose I/O lines. The control registers cover mode, clock divider, a read-only status word, power control, clock control, and three interrupt words: request, mask and status. These registers only store values. Nothing in the block acts on them, apart from one side effect on the power register. Two further registers hold the GPIO direction and the GPIO level.

The GPIO part drives `gpio_out` with the level register masked by the direction register. A bus write to the direction register or to either level offset compares the new masked output with the last recorded output. Every line that differs raises a one-cycle pulse on `gpio_chg`, and the recorded output is then updated. Edges on the external `gpio_in` lines set or clear level bits directly and raise no pulse.

The bus has no handshake. Every write is accepted at the clock edge on which `bus_we` is high. The read path always returns, one cycle later, the register selected by the address, so the block never applies back-pressure.

Top module: `aux_ctrl_gpio`

## Requirements
- R1: Only address bits [5:0] select a register. Higher address bits are ignored, so, for example, address 0x44 reaches the clock-divider register at offset 0x04.
- R2: A write takes effect at the rising edge where `bus_we` is high. `bus_rdata` is registered and shows the selected register one cycle after the address is presented. A read in the same cycle as a write to that register returns the value from before the write.
- R3: Writes keep only bits [15:0] of `bus_wdata`. The plain registers read back exactly what was stored: mode 0x00, divider 0x04, clock control 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C.
- R4: The status register at 0x08 always reads 0x0002 and ignores writes.
- R5: A write to the power register at 0x0C with data bit 7 set stores the data ORed with 0x8040. When bit 7 is clear, the data is stored unchanged.
- R6: Offsets with no register (for example 0x2C or 0x3C) read 0 and change no register when written.
- R7: Writing offset 0x24 or 0x28 stores the data ANDed with the current direction register (0x20). Both offsets read the stored level. A later direction write does not re-mask the stored level.
- R8: `gpio_out` always equals the level register ANDed with the direction register.
- R9: After a write to 0x20, 0x24 or 0x28, `gpio_chg` holds, for exactly the next cycle, the XOR of the new masked output with the last recorded output. The recorded output is then set to the new masked output. Otherwise `gpio_chg` is 0.
- R10: A rising edge on `gpio_in[i]` sets level bit i, and a falling edge clears it, whatever the direction bit is. Such an event changes no recorded output and raises no `gpio_chg` pulse.
- R11: After reset, status reads 0x0002. Every other register, the recorded output, `gpio_out`, `gpio_chg` and `bus_rdata` are 0.
- R12: When an input edge and a level write fall on the same clock edge, the input edge decides that bit, and the change pulse includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address; only bits [5:0] decoded |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | BUS_W (32) | Write data; bits [15:0] used |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 16 | External input lines, edge sensitive |
| gpio_out | output | 16 | Current level masked by direction |
| gpio_chg | output | 16 | One-cycle per-line change pulses |

## Verification
The bench targets the points an implementation most easily gets wrong:
- The power-register bit forcing. A design that ORs always, or never, reads back the wrong power word.
- Address aliasing. A design that decodes the full address misses the alias at 0x44.
- A stale recorded output. After input edges move the level, a design that refreshes the recorded output on input events, or that pulses on those events, produces the wrong `gpio_chg` mask on the next direction write.
- A level write and an input edge on the same clock edge. A design that lets the bus win here loses the input bit in both the level and the pulse.
- The read of a register in the same cycle it is written. A design with a combinational read path, or one that forwards the write data, returns the new value one cycle too early.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;
  localparam int REG_W   = 16;
  localparam int DEC_W   = 6;
  localparam int N_PLAIN = 6;

  localparam logic [DEC_W-1:0] OFS_MODE = 6'h00;
  localparam logic [DEC_W-1:0] OFS_CDIV = 6'h04;
  localparam logic [DEC_W-1:0] OFS_STAT = 6'h08;
  localparam logic [DEC_W-1:0] OFS_PWR  = 6'h0C;
  localparam logic [DEC_W-1:0] OFS_CLKC = 6'h10;
  localparam logic [DEC_W-1:0] OFS_IREQ = 6'h14;
  localparam logic [DEC_W-1:0] OFS_IMSK = 6'h18;
  localparam logic [DEC_W-1:0] OFS_ISTS = 6'h1C;
  localparam logic [DEC_W-1:0] OFS_GDIR = 6'h20;
  localparam logic [DEC_W-1:0] OFS_GSET = 6'h24;
  localparam logic [DEC_W-1:0] OFS_GGET = 6'h28;

  localparam logic [REG_W-1:0] STAT_RESET = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;
  localparam int               PWR_TRIG   = 7;

  // Offset of plain storage register i (mode, divider, clock control, irq words)
  function automatic logic [DEC_W-1:0] plain_ofs(input int i);
    case (i)
      0:       plain_ofs = OFS_MODE;
      1:       plain_ofs = OFS_CDIV;
      2:       plain_ofs = OFS_CLKC;
      3:       plain_ofs = OFS_IREQ;
      4:       plain_ofs = OFS_IMSK;
      default: plain_ofs = OFS_ISTS;
    endcase
  endfunction

  typedef struct packed {
    logic [N_PLAIN-1:0] plain;
    logic               pwr;
    logic               gdir;
    logic               glvl;
  } wr_strb_t;
endpackage

// File: rtl/aux_bus_decode.sv
module aux_bus_decode
  import aux_ctrl_pkg::*;
(
  input  logic [DEC_W-1:0] ofs,
  input  logic             we,
  output wr_strb_t         strb,
  output logic             known
);
  logic [N_PLAIN-1:0] plain_hit;

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_hit
    assign plain_hit[i] = (ofs == plain_ofs(i));
  end

  always_comb begin
    strb.plain = we ? plain_hit : '0;
    strb.pwr   = we && (ofs == OFS_PWR);
    strb.gdir  = we && (ofs == OFS_GDIR);
    strb.glvl  = we && ((ofs == OFS_GSET) || (ofs == OFS_GGET));
    known      = (|plain_hit) || (ofs == OFS_PWR) || (ofs == OFS_STAT) ||
                 (ofs == OFS_GDIR) || (ofs == OFS_GSET) || (ofs == OFS_GGET);
  end
endmodule

// File: rtl/aux_ctrl_regs.sv
module aux_ctrl_regs
  import aux_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strb_t         strb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] plain_q [N_PLAIN],
  output logic [REG_W-1:0] pwr_q,
  output logic [REG_W-1:0] stat_q
);
  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             plain_q[i] <= '0;
      else if (strb.plain[i]) plain_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pwr_q <= '0;
    else if (strb.pwr) pwr_q <= wdata[PWR_TRIG] ? (wdata | PWR_FORCE) : wdata;
  end

  assign stat_q = STAT_RESET;
endmodule

// File: rtl/aux_gpio_core.sv
module aux_gpio_core
  import aux_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             lvl_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] gpio_in,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] lvl_q,
  output logic [REG_W-1:0] gpio_out,
  output logic [REG_W-1:0] gpio_chg
);
  logic [REG_W-1:0] in_q, rise, fall;
  logic [REG_W-1:0] lvl_wr, lvl_nxt, dir_nxt, eff_nxt, rec_q;

  always_comb begin
    rise    = gpio_in & ~in_q;
    fall    = ~gpio_in & in_q;
    lvl_wr  = lvl_we ? (wdata & dir_q) : lvl_q;
    lvl_nxt = (lvl_wr | rise) & ~fall;
    dir_nxt = dir_we ? wdata : dir_q;
    eff_nxt = lvl_nxt & dir_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q     <= '0;
      lvl_q    <= '0;
      dir_q    <= '0;
      rec_q    <= '0;
      gpio_chg <= '0;
    end else begin
      in_q  <= gpio_in;
      lvl_q <= lvl_nxt;
      dir_q <= dir_nxt;
      if (dir_we || lvl_we) begin
        gpio_chg <= rec_q ^ eff_nxt;
        rec_q    <= eff_nxt;
      end else begin
        gpio_chg <= '0;
      end
    end
  end

  assign gpio_out = lvl_q & dir_q;
endmodule

// File: rtl/aux_ctrl_gpio.sv
module aux_ctrl_gpio
  import aux_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  gpio_in,
  output logic [REG_W-1:0]  gpio_out,
  output logic [REG_W-1:0]  gpio_chg
);
  localparam int HI_A = ADDR_W - DEC_W;
  localparam int HI_D = BUS_W - REG_W;

  logic [DEC_W-1:0] ofs;
  logic [REG_W-1:0] wd16;
  logic [HI_A-1:0]  unused_addr_hi;
  logic [HI_D-1:0]  unused_data_hi;

  assign ofs            = bus_addr[DEC_W-1:0];
  assign wd16           = bus_wdata[REG_W-1:0];
  assign unused_addr_hi = bus_addr[ADDR_W-1:DEC_W];
  assign unused_data_hi = bus_wdata[BUS_W-1:REG_W];

  wr_strb_t         strb;
  logic             known;
  logic [REG_W-1:0] plain_q [N_PLAIN];
  logic [REG_W-1:0] pwr_q, stat_q, dir_q, lvl_q;
  logic [REG_W-1:0] rd_mux;

  aux_bus_decode u_dec (
    .ofs   (ofs),
    .we    (bus_we),
    .strb  (strb),
    .known (known)
  );

  aux_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wdata   (wd16),
    .plain_q (plain_q),
    .pwr_q   (pwr_q),
    .stat_q  (stat_q)
  );

  aux_gpio_core u_gpio (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_we   (strb.gdir),
    .lvl_we   (strb.glvl),
    .wdata    (wd16),
    .gpio_in  (gpio_in),
    .dir_q    (dir_q),
    .lvl_q    (lvl_q),
    .gpio_out (gpio_out),
    .gpio_chg (gpio_chg)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_PLAIN; i++) begin
      if (ofs == plain_ofs(i)) rd_mux = plain_q[i];
    end
    case (ofs)
      OFS_PWR:            rd_mux = pwr_q;
      OFS_STAT:           rd_mux = stat_q;
      OFS_GDIR:           rd_mux = dir_q;
      OFS_GSET, OFS_GGET: rd_mux = lvl_q;
      default: ;
    endcase
    if (!known) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/aux_ctrl_gpio_chk.sv
module aux_ctrl_gpio_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic [15:0]       gpio_in,
  input logic [15:0]       gpio_out,
  input logic [15:0]       gpio_chg,
  input logic [15:0]       pwr_q
);
  logic [5:0]  o;
  logic [15:0] in_prev;
  logic        gpio_wr, undef;

  assign o       = bus_addr[5:0];
  assign gpio_wr = bus_we && (o == 6'h20 || o == 6'h24 || o == 6'h28);
  assign undef   = !(o <= 6'h28 && o[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_prev <= '0;
    else        in_prev <= gpio_in;
  end

  a_r4_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(o) == 6'h08) |-> bus_rdata == 16'h0002);

  a_r5_power_force: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && o == 6'h0C && bus_wdata[7]) |=> (pwr_q[15] && pwr_q[6] && pwr_q[7]));

  a_r6_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(undef)) |-> bus_rdata == 16'h0000);

  a_r7_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (o == 6'h24 || o == 6'h28) && gpio_in == in_prev)
      |=> (gpio_out & ~$past(bus_wdata[15:0])) == 16'h0000);

  a_r9_chg_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_chg) |-> $past(gpio_wr));
endmodule

bind aux_ctrl_gpio aux_ctrl_gpio_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .gpio_in   (gpio_in),
  .gpio_out  (gpio_out),
  .gpio_chg  (gpio_chg),
  .pwr_q     (pwr_q)
);

// File: tb/aux_ctrl_gpio_test.sv
module aux_ctrl_gpio_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] gpio_in = '0;
  logic [15:0] gpio_out;
  logic [15:0] gpio_chg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  aux_ctrl_gpio uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_in   (gpio_in),
    .gpio_out  (gpio_out),
    .gpio_chg  (gpio_chg)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [15:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'hDEAD_1234, 8'h00, 16'h1234, 4'd3},  // R3 truncation
    '{8'h04, 32'h0000_ABCD, 8'h04, 16'hABCD, 4'd3},  // R3
    '{8'h10, 32'h0000_5555, 8'h10, 16'h5555, 4'd3},  // R3
    '{8'h14, 32'h0000_00F1, 8'h14, 16'h00F1, 4'd3},  // R3
    '{8'h18, 32'h1234_8001, 8'h18, 16'h8001, 4'd3},  // R3
    '{8'h1C, 32'h0000_7FFE, 8'h1C, 16'h7FFE, 4'd3},  // R3
    '{8'h0C, 32'h0000_0081, 8'h0C, 16'h80C1, 4'd5},  // R5 forced bits
    '{8'h0C, 32'h0000_0041, 8'h0C, 16'h0041, 4'd5},  // R5 no force
    '{8'h0C, 32'h0000_0100, 8'h0C, 16'h0100, 4'd5},  // R5
    '{8'h08, 32'h0000_FFFF, 8'h08, 16'h0002, 4'd4},  // R4 read only
    '{8'h2C, 32'h0000_FFFF, 8'h2C, 16'h0000, 4'd6},  // R6 hole
    '{8'h3C, 32'h0000_FFFF, 8'h00, 16'h1234, 4'd6},  // R6 no side effect
    '{8'h44, 32'h0000_0F0F, 8'h04, 16'h0F0F, 4'd1},  // R1 alias write
    '{8'h20, 32'h0000_00FF, 8'hE0, 16'h00FF, 4'd1},  // R1 alias read
    '{8'h24, 32'h0000_FFFF, 8'h28, 16'h00FF, 4'd7},  // R7 masked
    '{8'h28, 32'h0000_1234, 8'h24, 16'h0034, 4'd7}   // R7 other offset
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; gpio_in = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] v;
    do_reset();
    // R11 reset state
    chk("R11 gpio_out", gpio_out, 16'h0);
    chk("R11 gpio_chg", gpio_chg, 16'h0);
    chk("R11 rdata", bus_rdata, 16'h0);
    rd(8'h08, v); chk("R11 status", v, 16'h0002);
    rd(8'h0C, v); chk("R11 power", v, 16'h0);
    rd(8'h20, v); chk("R11 dir", v, 16'h0);
    rd(8'h24, v); chk("R11 level", v, 16'h0);
    rd(8'h18, v); chk("R11 mask", v, 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, v);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].ex);
    end
    // R6 other registers untouched by hole writes
    rd(8'h10, v); chk("R6 clkctl kept", v, 16'h5555);
    rd(8'h0C, v); chk("R6 power kept", v, 16'h0100);

    // R2 same-cycle read of a write returns the old value, then the new one
    @(negedge clk);
    bus_addr = 8'h00; bus_we = 1'b1; bus_wdata = 32'h0000_0AAA;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R2 old value", bus_rdata, 16'h1234);
    @(negedge clk);
    chk("R2 new value", bus_rdata, 16'h0AAA);

    // GPIO sequence from a clean reset
    do_reset();
    wr(8'h20, 32'h00FF);
    chk("R9 no change", gpio_chg, 16'h0000);
    wr(8'h24, 32'h0F0F);
    chk("R9 pulse", gpio_chg, 16'h000F);
    chk("R8 out", gpio_out, 16'h000F);
    @(negedge clk);
    chk("R9 one cycle", gpio_chg, 16'h0000);
    wr(8'h20, 32'h0F03);
    chk("R9 dir change", gpio_chg, 16'h000C);
    chk("R8 out after dir", gpio_out, 16'h0003);
    rd(8'h28, v); chk("R7 level not remasked", v, 16'h000F);

    // R10 input edges
    @(negedge clk); gpio_in = 16'h0100;
    @(negedge clk);
    chk("R10 no pulse", gpio_chg, 16'h0000);
    chk("R10 rise out", gpio_out, 16'h0103);
    rd(8'h24, v); chk("R10 rise level", v, 16'h010F);
    @(negedge clk); gpio_in = 16'h0101;
    @(negedge clk); gpio_in = 16'h0100;
    @(negedge clk);
    chk("R10 fall out", gpio_out, 16'h0102);
    chk("R10 fall no pulse", gpio_chg, 16'h0000);
    wr(8'h20, 32'h0F03);
    chk("R9 stale record", gpio_chg, 16'h0101);

    // R12 input edge and level write on the same edge
    @(negedge clk);
    bus_addr = 8'h24; bus_we = 1'b1; bus_wdata = 32'h0; gpio_in = 16'h0300;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R12 pulse", gpio_chg, 16'h0302);
    chk("R12 out", gpio_out, 16'h0200);
    rd(8'h24, v); chk("R12 level", v, 16'h0200);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule